// File: doc/BRIEF.md
# Interrupt Enable Mask and Sticky Status Unit

This unit collects thirteen single-cycle event pulses from a serial port's receive, transmit and modem logic and turns each one into a sticky status bit. Software removes a status bit by writing a one to its position at the status offset. A separate mask decides which of the held status bits can reach the processor. The mask cannot be written directly. One write port sets mask bits and another clears them, so several software paths can change individual sources without a read-modify-write. The single interrupt output is a register fed by the OR of status AND mask.

Status bits latch whether or not their source is masked. Software therefore has to clear a stale status bit, for example transmit-empty, before it enables that source, or the interrupt fires at once. The bus decoding that makes the write strobes, and the logic that makes the event pulses, lie outside this block.

Top module: `irq_mask_stat`

## Requirements
- R1: While reset is high and in the first cycle after it, mask_o, status_o and irq_o are all zero.
- R2: An enable write sets every mask bit whose enable data bit is 1 at the next clock edge. Mask bits whose enable data bit is 0 keep their value.
- R3: A disable write clears every mask bit whose disable data bit is 1 at the next clock edge. Other mask bits keep their value. Without an enable or disable write, the mask does not change.
- R4: If an enable write and a disable write both carry a 1 for the same bit in the same cycle, that mask bit is 0 after the edge.
- R5: An event pulse on evt_i[i] sets status_o[i] at the next edge. The bit stays set until it is cleared. The bit order from bit 0 is: receive trigger, receive empty, receive full, transmit empty, transmit full, receive overflow, framing error, parity error, receive timeout, modem status change, transmit trigger, transmit nearly full, transmit overflow. All thirteen sources together are 0x1FFF.
- R6: A status clear write clears each status bit whose data bit is 1. Zero data bits leave their status bits unchanged.
- R7: If an event pulse and a clear write hit the same status bit in the same cycle, the bit is 1 after the edge.
- R8: A status bit latches even while its mask bit is 0. In that case irq_o stays 0.
- R9: irq_o in a cycle equals the OR of (status_o AND mask_o) from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 13 | Single-cycle event pulses, one per source |
| en_we_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 13 | Enable write data: 1 sets the mask bit |
| dis_we_i | input | 1 | Disable write strobe |
| dis_wdata_i | input | 13 | Disable write data: 1 clears the mask bit |
| clr_we_i | input | 1 | Status clear write strobe |
| clr_wdata_i | input | 13 | Status clear data: 1 clears the status bit |
| mask_o | output | 13 | Current mask (read-only) |
| status_o | output | 13 | Current sticky status |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Mask and status changes are due one clock edge after their strobe or pulse. The interrupt output is due one edge after that, so two edges after an event or enable write. The bench drives inputs on the falling edge. On each rising edge it advances its own model of mask, status and interrupt, using the pre-edge values for the interrupt, and it compares all three outputs at the next falling edge. This way every result is sampled in the first cycle in which it is due. The directed cases cover the same-cycle collisions of R4 and R7, a masked source (R8), and clear writes that carry zero bits. A seeded random run mixes all strobes together.

// File: rtl/irq_mask_stat_pkg.sv
package irq_mask_stat_pkg;

    localparam int NUM_SRC = 13;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    localparam src_vec_t ALL_SRC = '1;

    // Source positions; a neighbour decodes these, so the order is fixed.
    typedef enum int {
        SRC_RX_TRIG     = 0,
        SRC_RX_EMPTY    = 1,
        SRC_RX_FULL     = 2,
        SRC_TX_EMPTY    = 3,
        SRC_TX_FULL     = 4,
        SRC_RX_OVF      = 5,
        SRC_FRAME_ERR   = 6,
        SRC_PARITY_ERR  = 7,
        SRC_RX_TIMEOUT  = 8,
        SRC_MODEM_DELTA = 9,
        SRC_TX_TRIG     = 10,
        SRC_TX_NEARFULL = 11,
        SRC_TX_OVF      = 12
    } src_idx_e;

    typedef struct packed {
        logic     we;
        src_vec_t data;
    } wr_port_t;

    // Qualified write bits: data counts only when its strobe is high.
    function automatic src_vec_t wr_bits(input wr_port_t p);
        return p.we ? p.data : '0;
    endfunction

    // Mask update: set first, then clear, so a disable wins a collision.
    function automatic src_vec_t mask_next(input src_vec_t cur,
                                           input wr_port_t set_p,
                                           input wr_port_t clr_p);
        return (cur | wr_bits(set_p)) & ~wr_bits(clr_p);
    endfunction

endpackage

// File: rtl/ims_mask_reg.sv
module ims_mask_reg
    import irq_mask_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_port_t set_p,
    input  wr_port_t clr_p,
    output src_vec_t mask_q
);

    src_vec_t mask_d;

    always_comb begin
        mask_d = mask_next(mask_q, set_p, clr_p);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

endmodule

// File: rtl/ims_status_reg.sv
module ims_status_reg
    import irq_mask_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt,
    input  wr_port_t clr_p,
    output src_vec_t stat_q
);

    src_vec_t clr_bits;

    always_comb begin
        clr_bits = wr_bits(clr_p);
    end

    // One sticky cell per source; an event outranks a same-cycle clear.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[i] <= 1'b0;
            end else if (evt[i]) begin
                stat_q[i] <= 1'b1;
            end else if (clr_bits[i]) begin
                stat_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ims_irq_gen.sv
module ims_irq_gen
    import irq_mask_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t stat,
    input  src_vec_t mask,
    output logic     irq_q
);

    logic pend;

    always_comb begin
        pend = |(stat & mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= pend;
        end
    end

endmodule

// File: rtl/irq_mask_stat.sv
module irq_mask_stat
    import irq_mask_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [12:0] evt_i,
    input  logic        en_we_i,
    input  logic [12:0] en_wdata_i,
    input  logic        dis_we_i,
    input  logic [12:0] dis_wdata_i,
    input  logic        clr_we_i,
    input  logic [12:0] clr_wdata_i,
    output logic [12:0] mask_o,
    output logic [12:0] status_o,
    output logic        irq_o
);

    wr_port_t en_p, dis_p, clr_p;
    src_vec_t mask_q, stat_q;

    always_comb begin
        en_p.we    = en_we_i;
        en_p.data  = en_wdata_i;
        dis_p.we   = dis_we_i;
        dis_p.data = dis_wdata_i;
        clr_p.we   = clr_we_i;
        clr_p.data = clr_wdata_i;
    end

    ims_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_p  (en_p),
        .clr_p  (dis_p),
        .mask_q (mask_q)
    );

    ims_status_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_i),
        .clr_p  (clr_p),
        .stat_q (stat_q)
    );

    ims_irq_gen u_irq (
        .clk   (clk),
        .rst   (rst),
        .stat  (stat_q),
        .mask  (mask_q),
        .irq_q (irq_o)
    );

    assign mask_o   = mask_q;
    assign status_o = stat_q;

endmodule

// File: rtl/ims_checker.sv
module ims_checker (
    input logic        clk,
    input logic        rst,
    input logic [12:0] evt_i,
    input logic        en_we_i,
    input logic [12:0] en_wdata_i,
    input logic        dis_we_i,
    input logic [12:0] dis_wdata_i,
    input logic        clr_we_i,
    input logic [12:0] clr_wdata_i,
    input logic [12:0] mask_o,
    input logic [12:0] status_o,
    input logic        irq_o
);

    // R1: outputs are zero in the cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (mask_o == '0 && status_o == '0 && !irq_o));

    a_r2_enable_sets: assert property (@(posedge clk) disable iff (rst)
        (en_we_i && !dis_we_i) |=> ((mask_o & $past(en_wdata_i)) == $past(en_wdata_i)));

    // R3 and R4: a disable write always clears its bits
    a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
        dis_we_i |=> ((mask_o & $past(dis_wdata_i)) == '0));

    a_r3_mask_holds: assert property (@(posedge clk) disable iff (rst)
        (!en_we_i && !dis_we_i) |=> $stable(mask_o));

    // R5, R7, R8: an event always sets its status bit
    a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
        clr_we_i |=> ((status_o & $past(clr_wdata_i & ~evt_i)) == '0));

    a_r6_status_holds: assert property (@(posedge clk) disable iff (rst)
        (!(|evt_i) && !clr_we_i) |=> $stable(status_o));

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(status_o & mask_o))));

endmodule

bind irq_mask_stat ims_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .en_we_i     (en_we_i),
    .en_wdata_i  (en_wdata_i),
    .dis_we_i    (dis_we_i),
    .dis_wdata_i (dis_wdata_i),
    .clr_we_i    (clr_we_i),
    .clr_wdata_i (clr_wdata_i),
    .mask_o      (mask_o),
    .status_o    (status_o),
    .irq_o       (irq_o)
);

// File: tb/irq_mask_stat_test.sv
`timescale 1ns/1ps
module irq_mask_stat_test;
    import irq_mask_stat_pkg::*;

    localparam real HALF = 4.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] evt_i = '0;
    logic        en_we_i = 1'b0;
    logic [12:0] en_wdata_i = '0;
    logic        dis_we_i = 1'b0;
    logic [12:0] dis_wdata_i = '0;
    logic        clr_we_i = 1'b0;
    logic [12:0] clr_wdata_i = '0;
    logic [12:0] mask_o, status_o;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [12:0] m_mask = '0, m_stat = '0;
    logic        m_irq = 1'b0;

    always #(HALF) clk = ~clk;

    irq_mask_stat uut (
        .clk(clk), .rst(rst), .evt_i(evt_i),
        .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
        .dis_we_i(dis_we_i), .dis_wdata_i(dis_wdata_i),
        .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
        .mask_o(mask_o), .status_o(status_o), .irq_o(irq_o)
    );

    function automatic logic [12:0] f_mask(logic [12:0] cur, logic ew, logic [12:0] ed,
                                           logic dw, logic [12:0] dd);
        logic [12:0] s, c;
        s = ew ? ed : 13'd0;
        c = dw ? dd : 13'd0;
        return (cur | s) & ~c;
    endfunction

    function automatic logic [12:0] f_stat(logic [12:0] cur, logic [12:0] ev,
                                           logic cw, logic [12:0] cd);
        logic [12:0] c;
        c = cw ? cd : 13'd0;
        return (cur & ~c) | ev;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_i = '0; en_we_i = 0; en_wdata_i = '0; dis_we_i = 0;
        dis_wdata_i = '0; clr_we_i = 0; clr_wdata_i = '0;
    endtask

    // Inputs already driven (after a falling edge); advance one edge and check.
    task automatic cyc(string tag);
        @(posedge clk);
        m_irq  = |(m_stat & m_mask);
        m_mask = f_mask(m_mask, en_we_i, en_wdata_i, dis_we_i, dis_wdata_i);
        m_stat = f_stat(m_stat, evt_i, clr_we_i, clr_wdata_i);
        @(negedge clk);
        idle_inputs();
        chk(tag, "mask", 32'(mask_o), 32'(m_mask));
        chk(tag, "status", 32'(status_o), 32'(m_stat));
        chk(tag, "irq", 32'(irq_o), 32'(m_irq));
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'h5EED_0013));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "mask", 32'(mask_o), 0);
        chk("R1", "status", 32'(status_o), 0);
        chk("R1", "irq", 32'(irq_o), 0);
        rst = 0;
        cyc("R1");

        // R8: masked transmit-empty event latches, no interrupt
        evt_i = 13'(1 << SRC_TX_EMPTY);
        cyc("R8");
        cyc("R8");
        // R2: enable the stale source, interrupt follows one edge later
        en_we_i = 1; en_wdata_i = 13'(1 << SRC_TX_EMPTY);
        cyc("R2");
        cyc("R9");
        chk("R9", "irq high", 32'(irq_o), 1);
        // R2: zeros in enable data leave bits alone
        en_we_i = 1; en_wdata_i = 13'(1 << SRC_RX_TIMEOUT);
        cyc("R2");
        chk("R2", "mask value", 32'(mask_o), 32'h0108);
        // R3: disable one bit
        dis_we_i = 1; dis_wdata_i = 13'(1 << SRC_TX_EMPTY);
        cyc("R3");
        chk("R3", "mask value", 32'(mask_o), 32'h0100);
        cyc("R9");
        chk("R9", "irq low", 32'(irq_o), 0);
        // R4: enable and disable same bit
        en_we_i = 1; en_wdata_i = 13'h0201; dis_we_i = 1; dis_wdata_i = 13'h0001;
        cyc("R4");
        chk("R4", "mask value", 32'(mask_o), 32'h0300);
        // R6: clear with all-zero data keeps status
        clr_we_i = 1; clr_wdata_i = '0;
        cyc("R6");
        chk("R6", "status kept", 32'(status_o), 32'h0008);
        clr_we_i = 1; clr_wdata_i = 13'h0008;
        cyc("R6");
        chk("R6", "status cleared", 32'(status_o), 0);
        // R7: event and clear on the same bit
        evt_i = 13'(1 << SRC_PARITY_ERR); clr_we_i = 1; clr_wdata_i = 13'h1FFF;
        cyc("R7");
        chk("R7", "status set", 32'(status_o), 32'h0080);
        // R5: all sources, all enabled
        evt_i = ALL_SRC; en_we_i = 1; en_wdata_i = 13'h1FFF;
        cyc("R5");
        chk("R5", "status all", 32'(status_o), 32'h1FFF);
        cyc("R5");
        cyc("R5");
        clr_we_i = 1; clr_wdata_i = 13'h1FFF; dis_we_i = 1; dis_wdata_i = 13'h1FFF;
        cyc("R6");

        // Random mix
        for (int k = 0; k < 400; k++) begin
            evt_i       = 13'($urandom & $urandom & $urandom);
            en_we_i     = ($urandom % 4) == 0;
            en_wdata_i  = 13'($urandom & $urandom);
            dis_we_i    = ($urandom % 4) == 0;
            dis_wdata_i = 13'($urandom & $urandom);
            clr_we_i    = ($urandom % 3) == 0;
            clr_wdata_i = 13'($urandom);
            cyc("R9");
        end

        // R1: reset mid-run clears everything
        rst = 1;
        @(posedge clk);
        m_mask = '0; m_stat = '0; m_irq = 0;
        @(negedge clk);
        chk("R1", "mask", 32'(mask_o), 0);
        chk("R1", "status", 32'(status_o), 0);
        chk("R1", "irq", 32'(irq_o), 0);
        rst = 0;
        cyc("R1");
        report();
    end

endmodule